// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a processor-side access port and a PCIe core. It watches each access for a hit in a 64 KiB configuration window. A hit is turned into the address layout the core expects for a configuration cycle, together with a flag that selects a type 0 or a type 1 request. The window base is programmable. The bus, device and function of each request are not decoded from the access address. They come from a bank of 16-bit target registers, and the 4 KiB slot that the access falls in picks which register is used. Software therefore loads a target register first and then accesses the matching slot.

The register port takes 32-bit writes only. Each write loads the window base, or it loads two neighbouring target registers at once. An access that misses the window leaves the block unchanged and carries a miss flag. Every access result appears on the outputs one clock after the access is presented.

Top module: `cfgx_translator`

## Requirements
- R1: After reset the outputs `out_valid`, `out_cfg` and `out_miss` are low, the window base is 0 and every target register is 0.
- R2: An access hits the window when `acc_addr[31:16]` equals the stored base.
- R3: On a hit, `out_addr` is the selected 16-bit target register in [31:16] (bus in its bits 15:8, device in 7:3, function in 2:0, which lands bus in [31:24], device in [23:19] and function in [18:16]), zero in [15:12], and `acc_addr[11:0]` in [11:0].
- R4: On a hit, `out_type1` is high exactly when `acc_addr[15:12]` is nonzero, so slot 0 only ever issues type 0 requests.
- R5: The target register used is numbered by `acc_addr[14:12]`. Offsets in the upper half of the window (bit 15 set) reuse the same eight registers and are always type 1.
- R6: A write to register offset 0x930 + 4k (k = 0..3) loads target register 2k from data bits 15:0 and target register 2k+1 from data bits 31:16.
- R7: A write to register offset 0x92C stores data bits 31:16 as the window base. Data bits 15:0 have no effect.
- R8: On a miss, `out_cfg` and `out_type1` are low, `out_miss` is high and `out_addr` equals `acc_addr`.
- R9: `out_be` and `out_write` repeat `acc_be` and `acc_write` for both hits and misses.
- R10: `out_valid` is `acc_valid` delayed by one clock. Whenever `out_valid` is low, `out_cfg` and `out_miss` are low.
- R11: A register write affects only accesses presented after the write's clock edge. An access in the same cycle sees the old value. Writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ofs | input | 12 | Register byte offset |
| reg_wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_be | input | 4 | Access byte-lane enables |
| acc_write | input | 1 | Access is a write |
| out_valid | output | 1 | Translated access present |
| out_cfg | output | 1 | Access is a configuration request |
| out_miss | output | 1 | Access missed the window |
| out_type1 | output | 1 | Configuration request is type 1 |
| out_write | output | 1 | Forwarded write flag |
| out_be | output | 4 | Forwarded byte-lane enables |
| out_addr | output | 32 | Translated or forwarded address |

## Verification
Several properties are checked on every cycle: the one-cycle timing of `out_valid`, the rule that hit and miss exclude each other, the zero field and the copied low offset of a translated address, the type flag against the offset slot, the window compare against the stored base, the unchanged miss address and the lane pass-through. The assertions cannot show which target register fills the top half of a translated address. That depends on the sequence of earlier writes, so the bench's scenarios cover it: the paired loads, the aliasing of the upper half, ignored offsets, and a write that lands in the same cycle as an access.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int WIN_W     = 16;
    localparam int SLOT_W    = 12;
    localparam int BDF_W     = 16;
    localparam int REG_OFS_W = 12;
    localparam int BASE_W    = ADDR_W - WIN_W;

    typedef struct packed {
        logic              valid;
        logic              cfg;
        logic              miss;
        logic              type1;
        logic              write;
        logic [BE_W-1:0]   be;
        logic [ADDR_W-1:0] addr;
    } cfgx_out_t;
endpackage

// File: rtl/cfgx_regfile.sv
module cfgx_regfile
    import cfgx_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int BASE_OFS  = 'h92C,
    parameter int BDF_OFS   = 'h930
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [REG_OFS_W-1:0]              wr_ofs,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [BASE_W-1:0]                 base_hi,
    output logic [NUM_SLOTS-1:0][BDF_W-1:0]   bdf
);
    localparam int NUM_WORDS = NUM_SLOTS / 2;
    localparam logic [REG_OFS_W-1:0] BASE_SEL = REG_OFS_W'(BASE_OFS);

    typedef struct packed {
        logic [BASE_W-1:0]               base;
        logic [NUM_SLOTS-1:0][BDF_W-1:0] tgt;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  base_hit;
    logic [NUM_WORDS-1:0] word_hit;

    assign base_hit = wr_en && (wr_ofs == BASE_SEL);

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        localparam logic [REG_OFS_W-1:0] WORD_SEL = REG_OFS_W'(BDF_OFS + 4 * k);
        assign word_hit[k] = wr_en && (wr_ofs == WORD_SEL);
    end

    always_comb begin
        regs_d = regs_q;
        if (base_hit) begin
            regs_d.base = wr_data[DATA_W-1:DATA_W-BASE_W];
        end
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (word_hit[k]) begin
                regs_d.tgt[2*k]   = wr_data[BDF_W-1:0];
                regs_d.tgt[2*k+1] = wr_data[2*BDF_W-1:BDF_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign base_hi = regs_q.base;
    assign bdf     = regs_q.tgt;
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic [ADDR_W-1:0]                 acc_addr,
    input  logic [BASE_W-1:0]                 base_hi,
    input  logic [NUM_SLOTS-1:0][BDF_W-1:0]   bdf,
    output logic                              hit,
    output logic                              type1,
    output logic [ADDR_W-1:0]                 cfg_addr
);
    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam int GAP_W = WIN_W - SLOT_W;

    logic [IDX_W-1:0] slot;
    logic [BDF_W-1:0] target;

    assign hit    = (acc_addr[ADDR_W-1:WIN_W] == base_hi);
    assign slot   = acc_addr[SLOT_W +: IDX_W];
    assign target = bdf[slot];
    assign type1  = |acc_addr[WIN_W-1:SLOT_W];

    always_comb begin
        cfg_addr = {target, {GAP_W{1'b0}}, acc_addr[SLOT_W-1:0]};
    end
endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
    import cfgx_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int BASE_OFS  = 'h92C,
    parameter int BDF_OFS   = 'h930
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [11:0]          reg_wr_ofs,
    input  logic [31:0]          reg_wr_data,
    input  logic                 acc_valid,
    input  logic [31:0]          acc_addr,
    input  logic [3:0]           acc_be,
    input  logic                 acc_write,
    output logic                 out_valid,
    output logic                 out_cfg,
    output logic                 out_miss,
    output logic                 out_type1,
    output logic                 out_write,
    output logic [3:0]           out_be,
    output logic [31:0]          out_addr
);
    logic [BASE_W-1:0]               base_hi;
    logic [NUM_SLOTS-1:0][BDF_W-1:0] bdf;
    logic                            hit;
    logic                            type1;
    logic [ADDR_W-1:0]               cfg_addr;
    cfgx_out_t                       res_d, res_q;

    cfgx_regfile #(
        .NUM_SLOTS (NUM_SLOTS),
        .BASE_OFS  (BASE_OFS),
        .BDF_OFS   (BDF_OFS)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_ofs  (reg_wr_ofs),
        .wr_data (reg_wr_data),
        .base_hi (base_hi),
        .bdf     (bdf)
    );

    cfgx_decode #(
        .NUM_SLOTS (NUM_SLOTS)
    ) i_dec (
        .acc_addr (acc_addr),
        .base_hi  (base_hi),
        .bdf      (bdf),
        .hit      (hit),
        .type1    (type1),
        .cfg_addr (cfg_addr)
    );

    always_comb begin
        res_d = '0;
        if (acc_valid) begin
            res_d.valid = 1'b1;
            res_d.write = acc_write;
            res_d.be    = acc_be;
            if (hit) begin
                res_d.cfg   = 1'b1;
                res_d.type1 = type1;
                res_d.addr  = cfg_addr;
            end else begin
                res_d.miss  = 1'b1;
                res_d.addr  = acc_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_cfg   = res_q.cfg;
    assign out_miss  = res_q.miss;
    assign out_type1 = res_q.type1;
    assign out_write = res_q.write;
    assign out_be    = res_q.be;
    assign out_addr  = res_q.addr;
endmodule

// File: rtl/cfgx_translator_chk.sv
module cfgx_translator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [31:0] acc_addr,
    input logic [3:0]  acc_be,
    input logic        acc_write,
    input logic [15:0] base_hi,
    input logic        out_valid,
    input logic        out_cfg,
    input logic        out_miss,
    input logic        out_type1,
    input logic        out_write,
    input logic [3:0]  out_be,
    input logic [31:0] out_addr
);
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(acc_valid)));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_cfg && !out_miss));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cfg != out_miss));

    assert_miss_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_addr == $past(acc_addr) && !out_type1));

    assert_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_cfg |-> (out_addr[15:12] == 4'h0 && out_addr[11:0] == $past(acc_addr[11:0])));

    assert_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_cfg |-> (out_type1 == ($past(acc_addr[15:12]) != 4'h0)));

    assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_cfg |-> ($past(acc_addr[31:16]) == $past(base_hi)));

    assert_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_be == $past(acc_be) && out_write == $past(acc_write)));
endmodule

bind cfgx_translator cfgx_translator_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_be    (acc_be),
    .acc_write (acc_write),
    .base_hi   (base_hi),
    .out_valid (out_valid),
    .out_cfg   (out_cfg),
    .out_miss  (out_miss),
    .out_type1 (out_type1),
    .out_write (out_write),
    .out_be    (out_be),
    .out_addr  (out_addr)
);

// File: tb/test_cfgx_translator.sv
`timescale 1ns/1ps
module test_cfgx_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_wr_ofs = '0;
    logic [31:0] reg_wr_data = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [3:0]  acc_be = '0;
    logic        acc_write = 1'b0;
    logic        out_valid, out_cfg, out_miss, out_type1, out_write;
    logic [3:0]  out_be;
    logic [31:0] out_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] m_base = '0;
    logic [15:0] m_bdf [8];

    always #2.5 clk = ~clk;

    cfgx_translator i_cfgx_translator (
        .clk, .rst_n, .reg_wr_en, .reg_wr_ofs, .reg_wr_data,
        .acc_valid, .acc_addr, .acc_be, .acc_write,
        .out_valid, .out_cfg, .out_miss, .out_type1, .out_write, .out_be, .out_addr
    );

    // order: valid, cfg, miss, type1, write, be[3:0], addr[31:0]
    function automatic logic [40:0] model_out(logic [31:0] a, logic [3:0] be, logic wr);
        if (a[31:16] == m_base)
            return {1'b1, 1'b1, 1'b0, |a[15:12], wr, be, m_bdf[a[14:12]], 4'h0, a[11:0]};
        return {1'b1, 1'b0, 1'b1, 1'b0, wr, be, a};
    endfunction

    function automatic logic [40:0] dut_out();
        return {out_valid, out_cfg, out_miss, out_type1, out_write, out_be, out_addr};
    endfunction

    task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [11:0] ofs, input logic [31:0] d);
        if (ofs == 12'h92C) m_base = d[31:16];
        for (int k = 0; k < 4; k++) begin
            if (ofs == 12'(12'h930 + 4 * k)) begin
                m_bdf[2*k]   = d[15:0];
                m_bdf[2*k+1] = d[31:16];
            end
        end
    endtask

    task automatic reg_write(input logic [11:0] ofs, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_ofs = ofs; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model_write(ofs, d);
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic [3:0] be, input logic wr);
        logic [40:0] exp;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_be = be; acc_write = wr;
        exp = model_out(a, be, wr);
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, dut_out(), exp);
    endtask

    initial begin
        logic [40:0] exp;
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) m_bdf[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", {38'h0, out_valid, out_cfg, out_miss}, 41'h0);
        access("R1 reset base and slot0", 32'h0000_0123, 4'hF, 1'b0);

        reg_write(12'h92C, 32'h4000_ABCD);
        access("R7 base low half ignored", 32'h4000_0010, 4'h1, 1'b0);
        access("R8 old window now misses", 32'h0000_0010, 4'h3, 1'b1);

        reg_write(12'h930, 32'h0203_0108);
        access("R6 slot0 from low half", 32'h4000_0004, 4'hF, 1'b1);
        access("R4 slot1 type1 from high half", 32'h4000_1ABC, 4'h5, 1'b0);
        reg_write(12'h934, 32'hA1A2_B1B2);
        reg_write(12'h938, 32'hC1C2_D1D2);
        reg_write(12'h93C, 32'hE1E2_F1F2);
        for (int s = 0; s < 8; s++)
            access("R5 slot select", 32'h4000_0000 | (s << 12) | 32'h3FC, 4'h8, s[0]);
        access("R5 upper half aliases slot1", 32'h4000_9208, 4'hC, 1'b0);
        access("R3 field layout", 32'h4000_7FFF, 4'h2, 1'b1);

        reg_write(12'h940, 32'hDEAD_BEEF);
        reg_write(12'h928, 32'h1234_5678);
        access("R11 ignored offset slot0", 32'h4000_0040, 4'hF, 1'b0);
        access("R11 ignored offset slot7", 32'h4000_7040, 4'hF, 1'b0);

        // write and access in the same cycle: the access sees the old value
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_ofs = 12'h930; reg_wr_data = 32'h5555_6666;
        acc_valid = 1'b1; acc_addr = 32'h4000_0020; acc_be = 4'hF; acc_write = 1'b0;
        exp = model_out(32'h4000_0020, 4'hF, 1'b0);
        @(negedge clk);
        reg_wr_en = 1'b0; acc_valid = 1'b0;
        model_write(12'h930, 32'h5555_6666);
        check("R11 same-cycle write uses old", dut_out(), exp);
        @(negedge clk);
        check("R10 valid drops after one cycle", {38'h0, out_valid, out_cfg, out_miss}, 41'h0);
        access("R11 write visible next", 32'h4000_0020, 4'hF, 1'b0);
        access("R9 lanes on miss", 32'h7777_0001, 4'h9, 1'b1);

        for (int i = 0; i < 400; i++) begin
            int r;
            logic [31:0] a;
            r = $urandom_range(0, 7);
            if (r == 0) begin
                reg_write(12'(12'h92C + 4 * $urandom_range(0, 5)), $urandom());
            end else begin
                a = $urandom();
                if (r > 2) a[31:16] = m_base;
                access("R2 R3 R4 R8 R9 random", a, 4'($urandom()), 1'($urandom()));
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule